// File: doc/BRIEF.md
# Factory Bad-Block Scanner

After power-up this block visits every erase block of a NAND array in turn and learns which ones were marked defective at the factory. For each block it asks a lower-level NAND command sequencer for a single byte: the first byte of the spare area, at column 2048, in page 0 of that block. A byte of 00h marks the block bad. The result goes into a one-bit-per-block map. The block also keeps a running count of bad blocks and a flag that rises once the count goes past the device's lifetime allowance of 40.

The sequencer side is a plain request/response handshake with only one read in flight at a time. A request carries the row address, the column and the two command bytes of a page read. The scan only ever asks for reads, so it can never erase a block and wipe a factory mark. Once the scan has finished, a lookup port gives the bad flag of any block one cycle after the block number is presented.

Top module: `bad_block_scan`

## Requirements
- R1: While the synchronous reset `rst` is high and afterwards, until a scan starts: the map is clear, `badCount` is 0, `overflow`, `done`, `scanBusy` and `reqValid` are 0, and `lookupValid` is 0 during reset.
- R2: A one-cycle `start` while idle or finished clears the map, the count, `overflow` and `done`, and begins a scan from block 0. A `start` during a scan has no effect.
- R3: Blocks are requested in ascending order from 0 to 2047. `reqValid` rises one cycle after the scan starts and after each response, holds with a stable address until `reqReady`, and drops in the cycle after acceptance. No new request is raised before the response arrives.
- R4: Each request has `reqRow` = block number shifted left by 6 (page bits 5:0 zero), `reqCol` = 2048, `reqCmdSetup` = 00h and `reqCmdConfirm` = 30h. No erase command code is ever driven.
- R5: A response byte of exactly 00h marks the current block bad. Any other value (for example 01h, 80h, 5Ah, FFh) marks it good.
- R6: `badCount` equals the number of bad marks recorded since the last start. It changes only while scanning.
- R7: `overflow` rises in the cycle after the 41st bad mark is recorded (count above 40) and holds until reset or a new start. A count of exactly 40 leaves it low.
- R8: In the cycle after the response for block 2047 is accepted, `done` goes high and `scanBusy` goes low.
- R9: When not scanning, `lookupBad` and `lookupValid` show, one cycle after `lookupBlock` is presented, the map bit of that block, with `lookupValid` = 1.
- R10: While a scan is running, the lookup returns `lookupBad` = 0 and `lookupValid` = 0 on the following cycle.
- R11: A `rspValid` pulse that arrives when no request has been accepted (idle, or while `reqValid` is still waiting for `reqReady`) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a full scan (single-cycle pulse) |
| reqValid | output | 1 | Read request to the sequencer is pending |
| reqReady | input | 1 | Sequencer accepts the pending request |
| reqRow | output | 17 | Row address: block number with page bits zero |
| reqCol | output | 12 | Column address of the mark byte (2048) |
| reqCmdSetup | output | 8 | First command byte of the read (00h) |
| reqCmdConfirm | output | 8 | Confirm command byte of the read (30h) |
| rspValid | input | 1 | Response byte is valid |
| rspData | input | 8 | Byte read from the mark location |
| lookupBlock | input | 11 | Block number to look up |
| lookupBad | output | 1 | Bad flag of the looked-up block |
| lookupValid | output | 1 | Lookup result is meaningful (no scan running) |
| scanBusy | output | 1 | A scan is in progress |
| done | output | 1 | The last completed scan covered every block |
| badCount | output | 12 | Bad blocks found in the current or last scan |
| overflow | output | 1 | Bad-block count exceeded 40 |

## Verification
The hardest case to reach is a stray response that lands while a request is still waiting for acceptance. From outside, that cycle only exists if the responder deliberately holds back `reqReady`. The bench's responder stalls acceptance for a block-dependent number of cycles, and on request it fires a 00h response into that window, so a design that wrongly takes it would count an extra bad block. The two overflow edges, 40 and 41 bad marks, need whole-array scans with mark patterns spread over all 2048 blocks. A reset in the middle of a scan, with a response still in flight, checks that the cleared state survives the late response.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

  localparam logic [7:0] CMD_PAGE_READ_SETUP   = 8'h00;
  localparam logic [7:0] CMD_PAGE_READ_CONFIRM = 8'h30;
  localparam logic [7:0] FACTORY_BAD_BYTE      = 8'h00;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_AWAIT
  } scan_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic capture;
    logic stepBlock;
  } scan_strobe_t;

endpackage

// File: rtl/bbs_ctrl.sv
module bbs_ctrl
  import bbs_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         reqReady,
  input  logic         rspValid,
  input  logic         lastBlk,
  output scan_strobe_t strb,
  output logic         reqValid,
  output logic         scanBusy,
  output logic         done
);

  scan_state_e state, stateNxt;

  always_comb begin
    strb     = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.clearAll = 1'b1;
          stateNxt      = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (reqReady) stateNxt = ST_AWAIT;
      end
      ST_AWAIT: begin
        if (rspValid) begin
          strb.capture = 1'b1;
          if (lastBlk) begin
            stateNxt = ST_IDLE;
          end else begin
            strb.stepBlock = 1'b1;
            stateNxt       = ST_ISSUE;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNxt;
  end

  always_ff @(posedge clk) begin
    if (rst || strb.clearAll)           done <= 1'b0;
    else if (strb.capture && lastBlk)   done <= 1'b1;
  end

  assign reqValid = (state == ST_ISSUE);
  assign scanBusy = (state != ST_IDLE);

endmodule

// File: rtl/bbs_datapath.sv
module bbs_datapath
  import bbs_pkg::*;
#(
  parameter int NUM_BLOCKS = 2048,
  parameter int PAGE_BITS  = 6,
  parameter int BAD_LIMIT  = 40,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int ROW_W = BLK_W + PAGE_BITS,
  localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  scan_strobe_t     strb,
  input  logic             scanBusy,
  input  logic [7:0]       rspData,
  input  logic [BLK_W-1:0] lookupBlock,
  output logic             lastBlk,
  output logic [ROW_W-1:0] reqRow,
  output logic             lookupBad,
  output logic             lookupValid,
  output logic [CNT_W-1:0] badCount,
  output logic             overflow
);

  logic [BLK_W-1:0]      blkIdx;
  logic [NUM_BLOCKS-1:0] badMap;
  logic [NUM_BLOCKS-1:0] setHit;
  logic                  markBad;

  assign markBad = strb.capture && (rspData == FACTORY_BAD_BYTE);
  assign lastBlk = (blkIdx == BLK_W'(NUM_BLOCKS - 1));
  assign reqRow  = {blkIdx, {PAGE_BITS{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst || strb.clearAll) blkIdx <= '0;
    else if (strb.stepBlock)  blkIdx <= blkIdx + BLK_W'(1);
  end

  // one-hot decode of the block being recorded
  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_hit
    assign setHit[g] = markBad && (blkIdx == BLK_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst || strb.clearAll) badMap <= '0;
    else                      badMap <= badMap | setHit;
  end

  always_ff @(posedge clk) begin
    if (rst || strb.clearAll) begin
      badCount <= '0;
      overflow <= 1'b0;
    end else if (markBad) begin
      badCount <= badCount + CNT_W'(1);
      if (badCount >= CNT_W'(BAD_LIMIT)) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lookupBad   <= 1'b0;
      lookupValid <= 1'b0;
    end else begin
      lookupValid <= !scanBusy;
      lookupBad   <= !scanBusy && (32'(lookupBlock) < NUM_BLOCKS) && badMap[lookupBlock];
    end
  end

endmodule

// File: rtl/bad_block_scan.sv
module bad_block_scan
  import bbs_pkg::*;
#(
  parameter int NUM_BLOCKS = 2048,
  parameter int PAGE_BITS  = 6,
  parameter int COL_W      = 12,
  parameter int MARK_COL   = 2048,
  parameter int BAD_LIMIT  = 40,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int ROW_W = BLK_W + PAGE_BITS,
  localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             reqValid,
  input  logic             reqReady,
  output logic [ROW_W-1:0] reqRow,
  output logic [COL_W-1:0] reqCol,
  output logic [7:0]       reqCmdSetup,
  output logic [7:0]       reqCmdConfirm,
  input  logic             rspValid,
  input  logic [7:0]       rspData,
  input  logic [BLK_W-1:0] lookupBlock,
  output logic             lookupBad,
  output logic             lookupValid,
  output logic             scanBusy,
  output logic             done,
  output logic [CNT_W-1:0] badCount,
  output logic             overflow
);

  scan_strobe_t strb;
  logic         lastBlk;

  assign reqCol        = COL_W'(MARK_COL);
  assign reqCmdSetup   = CMD_PAGE_READ_SETUP;
  assign reqCmdConfirm = CMD_PAGE_READ_CONFIRM;

  bbs_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .lastBlk  (lastBlk),
    .strb     (strb),
    .reqValid (reqValid),
    .scanBusy (scanBusy),
    .done     (done)
  );

  bbs_datapath #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .PAGE_BITS  (PAGE_BITS),
    .BAD_LIMIT  (BAD_LIMIT)
  ) i_dp (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .scanBusy    (scanBusy),
    .rspData     (rspData),
    .lookupBlock (lookupBlock),
    .lastBlk     (lastBlk),
    .reqRow      (reqRow),
    .lookupBad   (lookupBad),
    .lookupValid (lookupValid),
    .badCount    (badCount),
    .overflow    (overflow)
  );

endmodule

// File: rtl/bbs_checker.sv
module bbs_checker #(
  parameter int NUM_BLOCKS = 2048,
  parameter int PAGE_BITS  = 6,
  parameter int COL_W      = 12,
  parameter int MARK_COL   = 2048,
  parameter int BAD_LIMIT  = 40,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int ROW_W = BLK_W + PAGE_BITS,
  localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             reqValid,
  input logic             reqReady,
  input logic [ROW_W-1:0] reqRow,
  input logic [COL_W-1:0] reqCol,
  input logic             rspValid,
  input logic             lookupBad,
  input logic             lookupValid,
  input logic             scanBusy,
  input logic             done,
  input logic [CNT_W-1:0] badCount,
  input logic             overflow
);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    reqValid && !reqReady |=> reqValid && $stable(reqRow));

  // R3
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    reqValid && reqReady |=> !reqValid);

  // R4
  req_addr_chk: assert property (@(posedge clk) disable iff (rst)
    reqValid |-> (reqCol == COL_W'(MARK_COL)) && (reqRow[PAGE_BITS-1:0] == '0));

  // R6
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !scanBusy && !start |=> $stable(badCount));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (32'(badCount) > BAD_LIMIT));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !scanBusy);

  // R10
  busy_lookup_chk: assert property (@(posedge clk) disable iff (rst)
    scanBusy |=> !lookupValid && !lookupBad);

  // R11
  stray_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    reqValid && rspValid |=> $stable(badCount));

endmodule

bind bad_block_scan bbs_checker #(
  .NUM_BLOCKS (NUM_BLOCKS),
  .PAGE_BITS  (PAGE_BITS),
  .COL_W      (COL_W),
  .MARK_COL   (MARK_COL),
  .BAD_LIMIT  (BAD_LIMIT)
) i_bbs_checker (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .reqRow      (reqRow),
  .reqCol      (reqCol),
  .rspValid    (rspValid),
  .lookupBad   (lookupBad),
  .lookupValid (lookupValid),
  .scanBusy    (scanBusy),
  .done        (done),
  .badCount    (badCount),
  .overflow    (overflow)
);

// File: tb/test_bad_block_scan.sv
`timescale 1ns/1ps
module test_bad_block_scan;

  localparam int N     = 2048;
  localparam int LIMIT = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        reqValid, reqReady;
  logic [16:0] reqRow;
  logic [11:0] reqCol;
  logic [7:0]  reqCmdSetup, reqCmdConfirm;
  logic        rspValid;
  logic [7:0]  rspData;
  logic [10:0] lookupBlock = '0;
  logic        lookupBad, lookupValid, scanBusy, done, overflow;
  logic [11:0] badCount;

  int  total = 0;
  int  bad = 0;
  int  mode = 0;
  bit  strayReq = 0;
  bit  lookupAuto = 1;
  int  lookupSel = 0;
  bit  finished = 0;

  always #2 clk = ~clk;

  bad_block_scan i_bad_block_scan (
    .clk(clk), .rst(rst), .start(start),
    .reqValid(reqValid), .reqReady(reqReady), .reqRow(reqRow), .reqCol(reqCol),
    .reqCmdSetup(reqCmdSetup), .reqCmdConfirm(reqCmdConfirm),
    .rspValid(rspValid), .rspData(rspData),
    .lookupBlock(lookupBlock), .lookupBad(lookupBad), .lookupValid(lookupValid),
    .scanBusy(scanBusy), .done(done), .badCount(badCount), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] markByte(input int m, input int b);
    case (m)
      0: begin
        if (b == 0 || b == 5 || b == N - 1) return 8'h00;
        if (b == 7) return 8'h01;
        if (b == 9) return 8'h80;
        return 8'hFF;
      end
      1: return (b % 50 == 3) ? 8'h00 : 8'h5A;
      default: return (b % 50 == 3 && b < 2000) ? 8'h00 : 8'hFF;
    endcase
  endfunction

  // behavioural reference
  bit mMap[N];
  int mCount, mBlk;
  bit mOvf, mDone, mBusy, mWait, mLkBad, mLkValid;

  always @(posedge clk) begin
    bit nb, nv;
    if (rst) begin
      foreach (mMap[i]) mMap[i] = 0;
      mCount = 0; mOvf = 0; mDone = 0; mBusy = 0; mWait = 0; mBlk = 0;
      mLkBad = 0; mLkValid = 0;
    end else begin
      nv = !mBusy;
      nb = mBusy ? 1'b0 : mMap[int'(lookupBlock)];
      if (!mBusy) begin
        if (start) begin
          foreach (mMap[i]) mMap[i] = 0;
          mCount = 0; mOvf = 0; mDone = 0; mBusy = 1; mWait = 0; mBlk = 0;
        end
      end else if (!mWait) begin
        if (reqReady) mWait = 1;
      end else if (rspValid) begin
        if (rspData == 8'h00) begin
          mMap[mBlk] = 1;
          mCount++;
          if (mCount > LIMIT) mOvf = 1;
        end
        if (mBlk == N - 1) begin
          mBusy = 0; mDone = 1;
        end else begin
          mBlk++; mWait = 0;
        end
      end
      mLkBad = nb; mLkValid = nv;
    end
  end

  // compare on every clock
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(scanBusy == mBusy, "R8", "scanBusy", scanBusy, mBusy);
      chk(done == mDone, "R8", "done", done, mDone);
      chk(reqValid == (mBusy && !mWait), "R3", "reqValid", reqValid, mBusy && !mWait);
      if (reqValid) begin
        chk(reqRow == {11'(mBlk), 6'b0}, "R4", "reqRow", reqRow, {11'(mBlk), 6'b0});
        chk(reqCol == 12'd2048, "R4", "reqCol", reqCol, 2048);
        chk(reqCmdSetup == 8'h00 && reqCmdConfirm == 8'h30, "R4", "cmd bytes",
            {reqCmdSetup, reqCmdConfirm}, 16'h0030);
      end
      chk(int'(badCount) == mCount, "R6", "badCount", badCount, mCount);
      chk(overflow == mOvf, "R7", "overflow", overflow, mOvf);
      if (mBusy || !mLkValid) begin
        chk(lookupValid == mLkValid && lookupBad == mLkBad, "R10", "lookup in scan",
            {lookupValid, lookupBad}, {mLkValid, mLkBad});
      end else begin
        chk(lookupValid == mLkValid && lookupBad == mLkBad, "R9", "lookup",
            {lookupValid, lookupBad}, {mLkValid, mLkBad});
      end
    end
  end

  // lookup address driver
  initial begin
    forever begin
      @(negedge clk);
      if (lookupAuto) lookupBlock = lookupBlock + 11'd37;
      else            lookupBlock = 11'(lookupSel);
    end
  end

  // sequencer responder
  initial begin
    int rb;
    reqReady = 0; rspValid = 0; rspData = 8'hFF;
    forever begin
      @(negedge clk);
      reqReady = 0; rspValid = 0;
      if (strayReq) begin
        rspValid = 1; rspData = 8'h00; strayReq = 0;
      end else if (reqValid && !rst) begin
        rb = int'(reqRow >> 6);
        repeat (rb % 3) @(negedge clk);
        reqReady = 1;
        @(negedge clk);
        reqReady = 0;
        repeat (1 + rb % 2) @(negedge clk);
        rspValid = 1; rspData = markByte(mode, rb);
        @(negedge clk);
        rspValid = 0;
      end
    end
  end

  task automatic pulseStart();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!done && n < 60000) begin @(negedge clk); n++; end
  endtask

  task automatic lookCheck(input int blk, input bit expBad, input string req);
    lookupAuto = 0; lookupSel = blk;
    repeat (2) @(negedge clk);
    chk(lookupValid == 1'b1 && lookupBad == expBad, req, $sformatf("lookup blk %0d", blk),
        {lookupValid, lookupBad}, {1'b1, expBad});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state held by reset
    chk(lookupValid == 0, "R1", "lookupValid in reset", lookupValid, 0);
    rst = 0;
    chk(badCount == 0 && !overflow && !done && !scanBusy && !reqValid, "R1", "reset state",
        {badCount, overflow, done, scanBusy, reqValid}, 0);
    lookCheck(0, 0, "R1");
    lookCheck(2047, 0, "R1");
    lookupAuto = 1;

    // scan 1: sparse marks, non-zero bytes that must read as good
    mode = 0;
    pulseStart();
    repeat (40) @(negedge clk);
    chk(scanBusy == 1, "R2", "busy after start", scanBusy, 1);
    pulseStart();          // R2: ignored while scanning
    repeat (7) @(negedge clk);
    strayReq = 1;          // R11: response with nothing accepted
    repeat (200) @(negedge clk);
    strayReq = 1;
    waitDone();
    chk(done == 1, "R8", "done after scan 1", done, 1);
    chk(badCount == 3, "R5", "count scan 1", badCount, 3);
    chk(overflow == 0, "R7", "no overflow scan 1", overflow, 0);
    lookCheck(0, 1, "R5");
    lookCheck(5, 1, "R5");
    lookCheck(7, 0, "R5");
    lookCheck(9, 0, "R5");
    lookCheck(2047, 1, "R5");
    lookCheck(1, 0, "R9");
    strayReq = 1;          // R11 while idle
    repeat (3) @(negedge clk);
    chk(badCount == 3, "R11", "count after idle stray", badCount, 3);
    lookupAuto = 1;

    // scan 2: 41 marks
    mode = 1;
    pulseStart();
    waitDone();
    chk(badCount == 41, "R6", "count scan 2", badCount, 41);
    chk(overflow == 1, "R7", "overflow at 41", overflow, 1);
    lookCheck(2003, 1, "R9");

    // scan 3: exactly 40 marks, previous results cleared
    mode = 2;
    lookupAuto = 1;
    pulseStart();
    @(negedge clk);
    chk(overflow == 0 && badCount == 0 && done == 0, "R2", "cleared by start",
        {overflow, badCount, done}, 0);
    waitDone();
    chk(badCount == 40, "R6", "count scan 3", badCount, 40);
    chk(overflow == 0, "R7", "no overflow at 40", overflow, 0);
    lookCheck(2003, 0, "R2");
    lookCheck(3, 1, "R5");

    // reset in the middle of a scan
    mode = 0;
    lookupAuto = 1;
    pulseStart();
    repeat (300) @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk(badCount == 0 && !scanBusy && !done && !overflow && !lookupValid, "R1",
        "mid-scan reset", {badCount, scanBusy, done, overflow, lookupValid}, 0);
    rst = 0;
    repeat (20) @(negedge clk);
    chk(badCount == 0 && !scanBusy, "R1", "idle after reset", {badCount, scanBusy}, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule